// File: doc/BRIEF.md
# Serial Flash Command Acceptance and Write Protection

This block sits behind the serial port of a small 256K x 8 flash device that is organised as four 64 KB sectors. It watches the serial slave lines (select, clock and data in mode 0) and the write-protect pin in the system clock domain. It decodes the single-byte command that opens each select frame and keeps the device status word. That word holds the write-enable latch, a two-bit protection level and a status-lock bit. The block also tracks a deep power-down state.

A command takes effect when select returns high. At that point the block decides whether a program, erase or status-write command may proceed. It checks four things: the frame length, the write-enable latch, the protection of the target sector and the hardware lock of the status word. For each accepted program or erase it issues a one-cycle request strobe with the target address to the array sequencer. A busy input from that sequencer stands in for the array and appears as the in-progress status bit.

Top module: `flash_wp_ctrl`

## Requirements
- R1: The protection level {BP1,BP0} marks part of the array read-only, where sector = address bits [17:16]. Level 00 leaves every sector writable. Level 01 locks sector 3. Level 10 locks sectors 2 and 3. Level 11 locks all four. A page program (0x02 + 3 address bytes) or sector erase (0xD8 + 3 address bytes) that targets a locked sector is refused, and the write-enable latch is left as it was.
- R2: A bulk erase (0xC7) is accepted only when both protection bits are 0. When accepted it raises the bulk request strobe.
- R3: A page program, sector erase, bulk erase or status write (0x01 + 1 data byte) is discarded with no effect unless the number of serial clock rising edges in its frame is a multiple of eight.
- R4: Page program, sector erase, bulk erase and status write are refused while the write-enable latch is 0. Only write enable (0x06) sets the latch. A frame whose first byte is incomplete does nothing.
- R5: The latch is cleared by reset, by write disable (0x04), and by every accepted status write, page program, sector erase or bulk erase.
- R6: While the write-protect pin is low and the status-lock bit is 1, a status write is ignored, and neither the protection bits nor the lock bit changes. With the pin high, a status write updates them.
- R7: Deep power-down (0xB9) is entered on that command. While in it, every command except release (0xAB) is ignored. Release leaves deep power-down. The state is visible on `deep_pd_o`.
- R8: While `busy_i` is high, every command is ignored, including read status (0x05). Status bit 0 follows `busy_i`.
- R9: The status word is bit 7 = status-lock, bit 3 = BP1, bit 2 = BP0, bit 1 = write-enable latch, bit 0 = in-progress. Bits 6:4 read 0, and the whole word is 0x00 after reset with `busy_i` low.
- R10: Commands act only on the rising edge of select. An accepted page program or sector erase pulses its request strobe for exactly one clock with the frame's 18-bit address on `req_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock, mode 0, slower than clk/4 |
| spi_mosi | input | 1 | Serial data into the device, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Array operation in progress |
| pgm_req_o | output | 1 | One-cycle page program request |
| erase_req_o | output | 1 | One-cycle sector erase request |
| bulk_req_o | output | 1 | One-cycle bulk erase request |
| req_addr_o | output | ADDR_W | Target address of the last request |
| status_o | output | 8 | Status word |
| deep_pd_o | output | 1 | Deep power-down state |

## Verification
The bench builds the block with its default parameters: an 18-bit address and two synchronizer stages. With these values the full four-sector map is in reach, and addresses at the very top and bottom of each sector can be aimed at directly. The two-stage synchronizer sets the latency from the rise of select to a strobe. The bench's serial timing leaves enough margin for that latency. Frame lengths of 12, 15 and 33 clocks exercise the length rule on either side of a byte boundary. A seven-clock frame shows that a partial opcode has no effect.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_PGM   = 2'd1,
    REQ_ERASE = 2'd2,
    REQ_BULK  = 2'd3
  } req_kind_e;

endpackage

// File: rtl/flash_region_map.sv
module flash_region_map (
  input  logic [1:0] prot_lvl,
  input  logic [1:0] sect,
  output logic       locked
);

  // Level n locks the top sectors: 01 -> 3, 10 -> 2..3, 11 -> all.
  always_comb begin
    unique case (prot_lvl)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (sect == 2'b11);
      2'b10:   locked = sect[1];
      default: locked = 1'b1;
    endcase
  end

endmodule

// File: rtl/flash_spi_frame.sv
module flash_spi_frame #(
  parameter int SYNC_STAGES = 2,
  parameter int ARG_BYTES   = 3,
  localparam int ARG_W      = 8 * ARG_BYTES,
  localparam int CNT_W      = $clog2(ARG_BYTES + 2)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             mosi_i,
  output logic             frame_end_o,
  output logic [7:0]       opcode_o,
  output logic [ARG_W-1:0] arg_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             whole_bytes_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(ARG_BYTES + 1);

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, mosi_sync;
  logic                   cs_d, sck_d;
  logic                   cs_s, sck_s, mosi_s;
  logic                   sck_rise;

  logic [2:0]       bit_q, bit_n;
  logic [CNT_W-1:0] byte_q, byte_n;
  logic [7:0]       sh_q, sh_n;
  logic [7:0]       op_q, op_n;
  logic [ARG_W-1:0] arg_q, arg_n;
  logic [7:0]       byte_val;

  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign mosi_s   = mosi_sync[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign byte_val = {sh_q[6:0], mosi_s};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync   <= '1;
      sck_sync  <= '0;
      mosi_sync <= '0;
      cs_d      <= 1'b1;
      sck_d     <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      cs_d      <= cs_s;
      sck_d     <= sck_s;
    end
  end

  always_comb begin
    bit_n  = bit_q;
    byte_n = byte_q;
    sh_n   = sh_q;
    op_n   = op_q;
    arg_n  = arg_q;
    if (cs_s) begin
      bit_n  = '0;
      byte_n = '0;
      sh_n   = '0;
      op_n   = '0;
      arg_n  = '0;
    end else if (sck_rise) begin
      sh_n  = byte_val;
      bit_n = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (byte_q == '0) op_n = byte_val;
        for (int k = 0; k < ARG_BYTES; k++) begin
          if (byte_q == CNT_W'(k + 1)) arg_n[8*(ARG_BYTES-1-k) +: 8] = byte_val;
        end
        if (byte_q != CNT_SAT) byte_n = byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
      op_q   <= '0;
      arg_q  <= '0;
    end else begin
      bit_q  <= bit_n;
      byte_q <= byte_n;
      sh_q   <= sh_n;
      op_q   <= op_n;
      arg_q  <= arg_n;
    end
  end

  assign frame_end_o   = cs_s & ~cs_d;
  assign opcode_o      = op_q;
  assign arg_o         = arg_q;
  assign byte_cnt_o    = byte_q;
  assign whole_bytes_o = (bit_q == 3'd0);

  // The opcode is held steady while clocks of later bytes arrive.
  AST_OPCODE_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cs_s && byte_q > CNT_W'(1)) |=> (op_q == $past(op_q) || cs_s)); // R10

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              wp_n,
  input  logic              busy_i,
  output logic              pgm_req_o,
  output logic              erase_req_o,
  output logic              bulk_req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        status_o,
  output logic              deep_pd_o
);

  import flash_wp_pkg::*;

  localparam int ARG_BYTES = 3;
  localparam int ARG_W     = 8 * ARG_BYTES;
  localparam int CNT_W     = $clog2(ARG_BYTES + 2);
  localparam int SECT_W    = 2;
  localparam logic [CNT_W-1:0] NEED_ADDR = CNT_W'(ARG_BYTES + 1);
  localparam logic [CNT_W-1:0] NEED_DATA = CNT_W'(2);

  // Reset: asserted at once, released after two clocks.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [SYNC_STAGES-1:0] wp_sync;
  logic                   wp_s;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wp_sync <= '1;
    else         wp_sync <= {wp_sync[SYNC_STAGES-2:0], wp_n};
  end
  assign wp_s = wp_sync[SYNC_STAGES-1];

  logic             frame_end, whole_bytes;
  logic [7:0]       opcode;
  logic [ARG_W-1:0] arg;
  logic [CNT_W-1:0] byte_cnt;

  flash_spi_frame #(
    .SYNC_STAGES (SYNC_STAGES),
    .ARG_BYTES   (ARG_BYTES)
  ) u_frame (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .cs_n_i        (spi_cs_n),
    .sck_i         (spi_sck),
    .mosi_i        (spi_mosi),
    .frame_end_o   (frame_end),
    .opcode_o      (opcode),
    .arg_o         (arg),
    .byte_cnt_o    (byte_cnt),
    .whole_bytes_o (whole_bytes)
  );

  logic              wel_q, wel_n;
  logic              lock_q, lock_n;
  logic [1:0]        lvl_q, lvl_n;
  logic              dp_q, dp_n;
  req_kind_e         req_q, req_n;
  logic [ADDR_W-1:0] addr_q, addr_n;

  logic [ADDR_W-1:0] frame_addr;
  logic [7:0]        data_byte;
  logic              tgt_locked, hw_locked;
  logic              unused_arg;

  assign frame_addr = arg[ADDR_W-1:0];
  assign data_byte  = arg[ARG_W-1 -: 8];
  assign hw_locked  = ~wp_s & lock_q;
  assign unused_arg = ^arg;

  flash_region_map u_tgt_map (
    .prot_lvl (lvl_q),
    .sect     (frame_addr[ADDR_W-1 -: SECT_W]),
    .locked   (tgt_locked)
  );

  always_comb begin
    wel_n  = wel_q;
    lock_n = lock_q;
    lvl_n  = lvl_q;
    dp_n   = dp_q;
    req_n  = REQ_NONE;
    addr_n = addr_q;
    if (frame_end) begin
      if (dp_q) begin
        if (opcode == OP_RES) dp_n = 1'b0;
      end else if (!busy_i) begin
        unique case (opcode)
          OP_WREN: wel_n = 1'b1;
          OP_WRDI: wel_n = 1'b0;
          OP_DP:   dp_n  = 1'b1;
          OP_WRSR: begin
            if (whole_bytes && byte_cnt >= NEED_DATA && wel_q && !hw_locked) begin
              lock_n = data_byte[7];
              lvl_n  = data_byte[3:2];
              wel_n  = 1'b0;
            end
          end
          OP_PP, OP_SE: begin
            if (whole_bytes && byte_cnt >= NEED_ADDR && wel_q && !tgt_locked) begin
              req_n  = (opcode == OP_PP) ? REQ_PGM : REQ_ERASE;
              addr_n = frame_addr;
              wel_n  = 1'b0;
            end
          end
          OP_BE: begin
            if (whole_bytes && wel_q && lvl_q == 2'b00) begin
              req_n = REQ_BULK;
              wel_n = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      lock_q <= 1'b0;
      lvl_q  <= 2'b00;
      dp_q   <= 1'b0;
      req_q  <= REQ_NONE;
      addr_q <= '0;
    end else begin
      wel_q  <= wel_n;
      lock_q <= lock_n;
      lvl_q  <= lvl_n;
      dp_q   <= dp_n;
      req_q  <= req_n;
      addr_q <= addr_n;
    end
  end

  assign pgm_req_o   = (req_q == REQ_PGM);
  assign erase_req_o = (req_q == REQ_ERASE);
  assign bulk_req_o  = (req_q == REQ_BULK);
  assign req_addr_o  = addr_q;
  assign status_o    = {lock_q, 3'b000, lvl_q, wel_q, busy_i};
  assign deep_pd_o   = dp_q;

  logic req_locked;
  flash_region_map u_req_map (
    .prot_lvl (lvl_q),
    .sect     (addr_q[ADDR_W-1 -: SECT_W]),
    .locked   (req_locked)
  );

  AST_REQ_UNLOCKED_SECT: assert property (@(posedge clk) disable iff (!rst_ni)
    (pgm_req_o || erase_req_o) |-> !req_locked); // R1
  AST_BULK_NEEDS_LVL0: assert property (@(posedge clk) disable iff (!rst_ni)
    bulk_req_o |-> (lvl_q == 2'b00)); // R2
  AST_REQ_CONSUMES_WEL: assert property (@(posedge clk) disable iff (!rst_ni)
    (pgm_req_o || erase_req_o || bulk_req_o) |-> ($past(wel_q) && !wel_q)); // R5
  AST_WEL_SET_BY_WREN: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(frame_end && opcode == OP_WREN)); // R4
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wp_s && lock_q) |=> $stable({lock_q, lvl_q})); // R6
  AST_DP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    dp_q |-> !(pgm_req_o || erase_req_o || bulk_req_o)); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (pgm_req_o || erase_req_o || bulk_req_o) |=> !(pgm_req_o || erase_req_o || bulk_req_o)); // R10
  AST_STROBE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_ni)
    (pgm_req_o || erase_req_o || bulk_req_o) |-> $past(frame_end)); // R10

endmodule

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int NV         = 40;

  typedef struct packed {
    logic [39:0] data;
    logic [5:0]  nbits;
    logic        wp;
    logic        bsy;
    logic [7:0]  st;
    logic        dp;
    logic [1:0]  req;
    logic [17:0] addr;
  } vec_t;

  // req: 0 none, 1 program, 2 sector erase, 3 bulk erase
  localparam vec_t VEC [NV] = '{
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     //  0 R4 wren
    '{40'h04_00000000, 6'd8,  1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 18'h0},     //  1 R5 wrdi
    '{40'h02_010000AA, 6'd40, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 18'h0},     //  2 R4 pp w/o latch
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     //  3
    '{40'h02_0123455A, 6'd40, 1'b1, 1'b0, 8'h00, 1'b0, 2'd1, 18'h12345}, //  4 R10 R5 pp
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     //  5
    '{40'hD8_03000000, 6'd32, 1'b1, 1'b0, 8'h00, 1'b0, 2'd2, 18'h30000}, //  6 R10 se
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     //  7
    '{40'hD8_03000000, 6'd33, 1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     //  8 R3 33 clocks
    '{40'h01_04000000, 6'd16, 1'b1, 1'b0, 8'h04, 1'b0, 2'd0, 18'h0},     //  9 R5 R9 wrsr lvl 01
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h06, 1'b0, 2'd0, 18'h0},     // 10
    '{40'h02_03FFFF00, 6'd40, 1'b1, 1'b0, 8'h06, 1'b0, 2'd0, 18'h0},     // 11 R1 sector 3 locked
    '{40'h02_02FFFF00, 6'd40, 1'b1, 1'b0, 8'h04, 1'b0, 2'd1, 18'h2FFFF}, // 12 R1 sector 2 open
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h06, 1'b0, 2'd0, 18'h0},     // 13
    '{40'hC7_00000000, 6'd8,  1'b1, 1'b0, 8'h06, 1'b0, 2'd0, 18'h0},     // 14 R2 be refused
    '{40'h01_08000000, 6'd16, 1'b1, 1'b0, 8'h08, 1'b0, 2'd0, 18'h0},     // 15 R1 lvl 10
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h0A, 1'b0, 2'd0, 18'h0},     // 16
    '{40'hD8_02000000, 6'd32, 1'b1, 1'b0, 8'h0A, 1'b0, 2'd0, 18'h0},     // 17 R1 sector 2 locked
    '{40'hD8_01000000, 6'd32, 1'b1, 1'b0, 8'h08, 1'b0, 2'd2, 18'h10000}, // 18 R1 sector 1 open
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h0A, 1'b0, 2'd0, 18'h0},     // 19
    '{40'h01_0C000000, 6'd16, 1'b1, 1'b0, 8'h0C, 1'b0, 2'd0, 18'h0},     // 20 R1 lvl 11
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h0E, 1'b0, 2'd0, 18'h0},     // 21
    '{40'h02_000000FF, 6'd40, 1'b1, 1'b0, 8'h0E, 1'b0, 2'd0, 18'h0},     // 22 R1 sector 0 locked
    '{40'h01_80000000, 6'd16, 1'b1, 1'b0, 8'h80, 1'b0, 2'd0, 18'h0},     // 23 R6 R9 lock bit set
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h82, 1'b0, 2'd0, 18'h0},     // 24
    '{40'hC7_00000000, 6'd12, 1'b1, 1'b0, 8'h82, 1'b0, 2'd0, 18'h0},     // 25 R3 12 clocks
    '{40'hC7_00000000, 6'd8,  1'b1, 1'b0, 8'h80, 1'b0, 2'd3, 18'h0},     // 26 R2 be accepted
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h82, 1'b0, 2'd0, 18'h0},     // 27
    '{40'h01_0C000000, 6'd16, 1'b0, 1'b0, 8'h82, 1'b0, 2'd0, 18'h0},     // 28 R6 hw locked
    '{40'h01_00000000, 6'd16, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 18'h0},     // 29 R6 pin high
    '{40'h06_00000000, 6'd8,  1'b1, 1'b1, 8'h01, 1'b0, 2'd0, 18'h0},     // 30 R8 busy
    '{40'h05_00000000, 6'd8,  1'b1, 1'b1, 8'h01, 1'b0, 2'd0, 18'h0},     // 31 R8 rdsr busy
    '{40'h06_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     // 32
    '{40'h01_0C000000, 6'd15, 1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     // 33 R3 15 clocks
    '{40'hB9_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b1, 2'd0, 18'h0},     // 34 R7 enter dp
    '{40'h04_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b1, 2'd0, 18'h0},     // 35 R7 wrdi ignored
    '{40'h02_00000000, 6'd40, 1'b1, 1'b0, 8'h02, 1'b1, 2'd0, 18'h0},     // 36 R7 pp ignored
    '{40'hAB_00000000, 6'd8,  1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 18'h0},     // 37 R7 release
    '{40'h04_00000000, 6'd8,  1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 18'h0},     // 38 R5
    '{40'h06_00000000, 6'd7,  1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 18'h0}      // 39 R4 partial opcode
  };

  logic        clk, rst_n, cs_n, sck, mosi, wp_n, busy;
  logic        pgm_req, erase_req, bulk_req, deep_pd;
  logic [17:0] req_addr;
  logic [7:0]  status;

  int n_chk, n_bad;
  int cnt_pgm, cnt_erase, cnt_bulk;
  logic [17:0] seen_addr;
  bit done;

  flash_wp_ctrl i_flash_wp_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (cs_n),
    .spi_sck     (sck),
    .spi_mosi    (mosi),
    .wp_n        (wp_n),
    .busy_i      (busy),
    .pgm_req_o   (pgm_req),
    .erase_req_o (erase_req),
    .bulk_req_o  (bulk_req),
    .req_addr_o  (req_addr),
    .status_o    (status),
    .deep_pd_o   (deep_pd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (pgm_req)   begin cnt_pgm++;   seen_addr <= req_addr; end
    if (erase_req) begin cnt_erase++; seen_addr <= req_addr; end
    if (bulk_req)  cnt_bulk++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [39:0] data, input int nbits);
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF_SCK) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = data[39-b];
      repeat (HALF_SCK) @(negedge clk);
      sck = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF_SCK) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    cnt_pgm = 0; cnt_erase = 0; cnt_bulk = 0; seen_addr = '0;
    cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1; busy = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    check("R9 reset status", 32'(status), 32'h00);
    check("R7 reset deep_pd", 32'(deep_pd), 32'h0);
    check("R10 no strobe after reset", 32'(cnt_pgm + cnt_erase + cnt_bulk), 32'h0);

    for (int v = 0; v < NV; v++) begin
      int p0, e0, b0;
      string tag;
      wp_n = VEC[v].wp;
      busy = VEC[v].bsy;
      p0 = cnt_pgm; e0 = cnt_erase; b0 = cnt_bulk;
      send_frame(VEC[v].data, int'(VEC[v].nbits));
      tag = $sformatf("vector %0d", v);
      check({tag, " status"}, 32'(status), 32'(VEC[v].st));
      check({tag, " deep_pd"}, 32'(deep_pd), 32'(VEC[v].dp));
      check({tag, " program strobes"}, 32'(cnt_pgm - p0), (VEC[v].req == 2'd1) ? 32'd1 : 32'd0);
      check({tag, " erase strobes"}, 32'(cnt_erase - e0), (VEC[v].req == 2'd2) ? 32'd1 : 32'd0);
      check({tag, " bulk strobes"}, 32'(cnt_bulk - b0), (VEC[v].req == 2'd3) ? 32'd1 : 32'd0);
      if (VEC[v].req == 2'd1 || VEC[v].req == 2'd2)
        check({tag, " R10 address"}, 32'(seen_addr), 32'(VEC[v].addr));
    end
    busy = 1'b0;

    // R5: reset clears the latch
    send_frame(40'h06_00000000, 8);
    check("R5 latch set before reset", 32'(status), 32'h02);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R5 latch cleared by reset", 32'(status), 32'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: nothing happens before select rises
    begin
      @(negedge clk); cs_n = 1'b0;
      repeat (HALF_SCK) @(negedge clk);
      for (int b = 0; b < 8; b++) begin
        mosi = 1'(8'h06 >> (7 - b));
        repeat (HALF_SCK) @(negedge clk);
        sck = 1'b1;
        repeat (HALF_SCK) @(negedge clk);
        sck = 1'b0;
      end
      repeat (12) @(negedge clk);
      check("R10 no effect while select low", 32'(status), 32'h00);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
      check("R10 effect after select rises", 32'(status), 32'h02);
    end

    // R8: in-progress bit tracks busy
    busy = 1'b1; @(negedge clk);
    check("R8 wip bit", 32'(status), 32'h03);
    busy = 1'b0; @(negedge clk);
    check("R8 wip bit clear", 32'(status), 32'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule